// File: doc/BRIEF.md
# Timestamped GPIO Capture/Compare Unit

This block ties a single pin to a free-running 64-bit time counter. It has two modes. In input mode it watches the pin. When the pin rises and then stays high long enough, it copies the counter into a capture register. In output mode it compares the counter with a programmed target time. On a match it drives a fixed-width pulse on the pin and records the match time in the same capture register. An optional periodic setting moves the target forward by a programmed interval after every match, so the pulses repeat.

A running event count relates each captured time to its place in the sequence of events. Software reads the captured time through a small word-wide register port. Reading the low word of the capture register also copies the live count into a snapshot register. Software can then read the timestamp and its event number as a consistent pair. The pin input is assumed to arrive already on the block's clock domain. A two-stage synchronizer still sits in front of the qualifier.

Top module: `tgpio_unit`

## Requirements
- R1: After reset, pin_out and pin_oe are 0 and every register word reads back as 0.
- R2: In input mode (control bit0 enable = 1, bit1 direction = 0), a pin rise that stays high for two synchronized cycles is recorded. The capture register then holds the timer value seen three clock edges after the first edge that samples the pin high. The event count increases by one.
- R3: An input pulse that lasts only one cycle is ignored. A level held high for any length gives exactly one event; the pin must go low before the next event can be recognized.
- R4: In output mode (enable = 1, direction = 1) with the unit armed, the clock edge at which timer equals the target loads the target value into capture and adds one to the count. pin_out is then high for exactly two cycles. pin_oe equals enable AND direction.
- R5: When control bit2 (periodic) is set, every output event replaces the target with target + interval. Further events therefore follow at that spacing.
- R6: When periodic is clear, the unit disarms after one output event. A control write with enable = 1, or a write to the target high word, arms it again.
- R7: A read of the capture low word copies the live event count into the snapshot register. The snapshot keeps that value until the next such read.
- R8: A control write with enable = 0 sets the event count to zero and immediately ends any output pulse. In output mode, a pulse stops as soon as the block leaves output mode.
- R9: Register map with 32-bit words: 0x00 control, 0x08 target, 0x10 interval, 0x18 capture (read-only), 0x20 snapshot (read-only, zero-extended count). Each 64-bit register has its low word at +0 and its high word at +4. Read data appears on the cycle after the read strobe; it is 0 when no read is in progress.
- R10: Pin input has no effect in output mode. No output event happens in input mode or while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Byte address of the 32-bit word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| timer | input | 64 | Free-running time counter |
| pin_in | input | 1 | Pin level seen by the input path |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The embedded assertions check several properties on every cycle:
- each qualified input event is a single cycle;
- every match or clear changes the event count in the right way;
- a read of the capture low word leaves the prior count in the snapshot;
- a periodic match advances the target by the interval, and a one-shot match disarms the unit;
- a started pulse lasts beyond one cycle and ends when output mode is left.

Only the bench scenarios can show the following:
- the exact timer value captured after the synchronizer latency;
- that a one-cycle pulse and a long hold each give the expected number of events;
- that re-arming through a target write works;
- that the number of periodic events matches the time elapsed.

// File: rtl/tgpio_pkg.sv
package tgpio_pkg;

    localparam int TIME_W = 64;
    localparam int REG_AW = 6;
    localparam int WORD_W = 32;

    // control word layout: bit0 enable, bit1 direction (1 = drive pin), bit2 periodic
    typedef struct packed {
        logic periodic;
        logic dir_out;
        logic enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_TGT  = 3'd1,
        SEL_INTV = 3'd2,
        SEL_CAP  = 3'd3,
        SEL_SNAP = 3'd4
    } reg_sel_e;

    function automatic logic [WORD_W-1:0] word_pick(input logic [TIME_W-1:0] v,
                                                    input logic hi);
        return hi ? v[TIME_W-1:WORD_W] : v[WORD_W-1:0];
    endfunction

    function automatic logic [TIME_W-1:0] word_merge(input logic [TIME_W-1:0] v,
                                                     input logic [WORD_W-1:0] w,
                                                     input logic hi);
        logic [TIME_W-1:0] r;
        r = v;
        if (hi) r[TIME_W-1:WORD_W] = w;
        else    r[WORD_W-1:0]      = w;
        return r;
    endfunction

endpackage

// File: rtl/tgpio_in_qual.sv
module tgpio_in_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_HIGH    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    input  logic active,
    output logic evt
);
    localparam int RUN_W = $clog2(MIN_HIGH + 1);

    logic [SYNC_STAGES-1:0] sr;
    logic                   lvl;
    logic [RUN_W-1:0]       run;
    logic                   taken;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= pin_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[SYNC_STAGES-2:0], pin_in};
            end
        end
    endgenerate

    assign lvl = sr[SYNC_STAGES-1];
    assign evt = active && lvl && !taken && (run >= RUN_W'(MIN_HIGH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= '0;
            taken <= 1'b0;
        end else if (!lvl) begin
            run   <= '0;
            taken <= 1'b0;
        end else begin
            if (run < RUN_W'(MIN_HIGH - 1)) run <= run + 1'b1;
            if (evt) taken <= 1'b1;
        end
    end

    // R3
    single_evt_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);

    // R3
    evt_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
        evt |-> $past(lvl));

endmodule

// File: rtl/tgpio_out_sched.sv
module tgpio_out_sched
    import tgpio_pkg::*;
#(
    parameter int PULSE_CYC = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                active,
    input  logic                periodic,
    input  logic                clear,
    input  logic                arm_req,
    input  logic                tgt_wr_lo,
    input  logic                tgt_wr_hi,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [TIME_W-1:0]   intv,
    input  logic [TIME_W-1:0]   timer,
    output logic                fire,
    output logic [TIME_W-1:0]   target,
    output logic                pin_out
);
    localparam int PW = $clog2(PULSE_CYC + 1);

    logic          armed;
    logic [PW-1:0] pulse;
    logic          pulse_nz;

    assign fire     = active && armed && (timer == target);
    assign pulse_nz = (pulse != '0);
    assign pin_out  = pulse_nz && active;

    always_ff @(posedge clk) begin
        if (rst)                    armed <= 1'b0;
        else if (clear)             armed <= 1'b0;
        else if (arm_req)           armed <= 1'b1;
        else if (fire && !periodic) armed <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                    target <= '0;
        else if (tgt_wr_lo)         target <= word_merge(target, wdata, 1'b0);
        else if (tgt_wr_hi)         target <= word_merge(target, wdata, 1'b1);
        else if (fire && periodic)  target <= target + intv;
    end

    always_ff @(posedge clk) begin
        if (rst || clear || !active) pulse <= '0;
        else if (fire)               pulse <= PW'(PULSE_CYC);
        else if (pulse_nz)           pulse <= pulse - 1'b1;
    end

    // R5
    periodic_step_chk: assert property (@(posedge clk) disable iff (rst)
        fire && periodic && !tgt_wr_lo && !tgt_wr_hi
        |=> target == $past(target) + $past(intv));

    // R6
    oneshot_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        fire && !periodic && !arm_req && !clear |=> !armed);

    // R4
    pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pin_out) && active && !clear |=> pin_out);

    // R8
    pulse_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (clear || !active) |=> !pulse_nz);

endmodule

// File: rtl/tgpio_evt_log.sv
module tgpio_evt_log
    import tgpio_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               evt,
    input  logic               snap_req,
    input  logic [TIME_W-1:0]  timer,
    output logic [TIME_W-1:0]  cap,
    output logic [CNT_W-1:0]   snap
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)      cap <= '0;
        else if (evt) cap <= timer;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (evt)     cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)           snap <= '0;
        else if (snap_req) snap <= cnt;
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        evt && !clear |=> cnt == $past(cnt) + 1'b1);

    // R8
    count_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> cnt == '0);

    // R7
    snap_take_chk: assert property (@(posedge clk) disable iff (rst)
        snap_req |=> snap == $past(cnt));

endmodule

// File: rtl/tgpio_unit.sv
module tgpio_unit
    import tgpio_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_HIGH    = 2,
    parameter int PULSE_CYC   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    input  logic [TIME_W-1:0]   timer,
    input  logic                pin_in,
    output logic                pin_out,
    output logic                pin_oe
);
    ctrl_t             ctrl;
    logic [TIME_W-1:0] intv;
    logic [TIME_W-1:0] target;
    logic [TIME_W-1:0] cap;
    logic [CNT_W-1:0]  snap;
    reg_sel_e          sel;
    logic              hi;
    logic              ctrl_wr, clear, arm_req;
    logic              tgt_wr_lo, tgt_wr_hi;
    logic              snap_req, in_evt, fire;
    logic              out_active, in_active;
    logic [WORD_W-1:0] rd_mux;
    logic              unused_bits;

    assign sel         = reg_sel_e'(reg_addr[5:3]);
    assign hi          = reg_addr[2];
    assign unused_bits = ^reg_addr[1:0];

    assign ctrl_wr   = reg_wr && (sel == SEL_CTRL) && !hi;
    assign clear     = ctrl_wr && !reg_wdata[0];
    assign tgt_wr_lo = reg_wr && (sel == SEL_TGT) && !hi;
    assign tgt_wr_hi = reg_wr && (sel == SEL_TGT) && hi;
    assign arm_req   = (ctrl_wr && reg_wdata[0]) || tgt_wr_hi;
    assign snap_req  = reg_rd && (sel == SEL_CAP) && !hi;

    assign out_active = ctrl.enable && ctrl.dir_out;
    assign in_active  = ctrl.enable && !ctrl.dir_out;
    assign pin_oe     = out_active;

    always_ff @(posedge clk) begin
        if (rst)          ctrl <= '0;
        else if (ctrl_wr) ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) intv <= '0;
        else if (reg_wr && (sel == SEL_INTV)) intv <= word_merge(intv, reg_wdata, hi);
    end

    tgpio_in_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .MIN_HIGH    (MIN_HIGH)
    ) u_in (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .active (in_active),
        .evt    (in_evt)
    );

    tgpio_out_sched #(
        .PULSE_CYC (PULSE_CYC)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .active    (out_active),
        .periodic  (ctrl.periodic),
        .clear     (clear),
        .arm_req   (arm_req),
        .tgt_wr_lo (tgt_wr_lo),
        .tgt_wr_hi (tgt_wr_hi),
        .wdata     (reg_wdata),
        .intv      (intv),
        .timer     (timer),
        .fire      (fire),
        .target    (target),
        .pin_out   (pin_out)
    );

    tgpio_evt_log #(
        .CNT_W (CNT_W)
    ) u_log (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .evt      (in_evt || fire),
        .snap_req (snap_req),
        .timer    (timer),
        .cap      (cap),
        .snap     (snap)
    );

    always_comb begin
        case (sel)
            SEL_CTRL: rd_mux = hi ? '0 : WORD_W'(ctrl);
            SEL_TGT:  rd_mux = word_pick(target, hi);
            SEL_INTV: rd_mux = word_pick(intv, hi);
            SEL_CAP:  rd_mux = word_pick(cap, hi);
            SEL_SNAP: rd_mux = word_pick(TIME_W'(snap), hi);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !reg_rd) reg_rdata <= '0;
        else                reg_rdata <= rd_mux;
    end

    // R10
    modes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_evt && fire));

    // R4
    oe_follows_mode_chk: assert property (@(posedge clk) disable iff (rst)
        pin_out |-> pin_oe);

endmodule

// File: tb/sim_tgpio_unit.sv
module sim_tgpio_unit;
    import tgpio_pkg::*;

    localparam logic [63:0] T_START = 64'h0000_0001_FFFF_FF00;

    logic        clk = 1'b0, rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] timer = T_START;
    logic        pin_in = 1'b0;
    logic        pin_out, pin_oe;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    always @(posedge clk) timer <= rst ? T_START : timer + 64'd1;

    tgpio_unit u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .timer(timer), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_en, m_dir, m_per, m_armed, m_taken, m_high_once;
    logic [63:0] m_tgt, m_int, m_cap;
    int unsigned m_cnt, m_snap, m_pulse;
    logic [31:0] m_rdata;
    bit          pin_hist[$];

    function automatic logic [31:0] m_read(logic [5:0] a);
        logic [63:0] v;
        case (a[5:3])
            3'd0: v = {61'd0, m_per, m_dir, m_en};
            3'd1: v = m_tgt;
            3'd2: v = m_int;
            3'd3: v = m_cap;
            3'd4: v = {32'd0, m_snap};
            default: v = '0;
        endcase
        if (a[5:3] == 3'd0 && a[2]) return 32'd0;
        return a[2] ? v[63:32] : v[31:0];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_dir = 0; m_per = 0; m_armed = 0; m_taken = 0; m_high_once = 0;
            m_tgt = '0; m_int = '0; m_cap = '0; m_cnt = 0; m_snap = 0; m_pulse = 0;
            m_rdata = '0; pin_hist.delete();
        end else begin
            bit lvl, ev_in, ev_out, act_out, clr, arm;
            lvl     = (pin_hist.size() >= 2) ? pin_hist[1] : 1'b0;
            act_out = m_en && m_dir;
            ev_in   = m_en && !m_dir && lvl && m_high_once && !m_taken;
            ev_out  = act_out && m_armed && (timer == m_tgt);
            clr     = reg_wr && reg_addr[5:2] == 4'd0 && !reg_wdata[0];
            arm     = reg_wr && ((reg_addr[5:2] == 4'd0 && reg_wdata[0]) || reg_addr[5:2] == 4'd3);
            m_rdata = reg_rd ? m_read(reg_addr) : 32'd0;
            if (reg_rd && reg_addr[5:2] == 4'd6) m_snap = m_cnt;
            // input qualifier history
            if (!lvl) begin m_taken = 0; m_high_once = 0; end
            else begin m_high_once = 1; if (ev_in) m_taken = 1; end
            pin_hist.push_front(pin_in);
            if (pin_hist.size() > 2) void'(pin_hist.pop_back());
            // events
            if (ev_in || ev_out) begin m_cap = timer; m_cnt++; end
            if (clr) m_cnt = 0;
            if (clr || !act_out) m_pulse = 0;
            else if (ev_out) m_pulse = 2;
            else if (m_pulse != 0) m_pulse--;
            if (clr) m_armed = 0;
            else if (arm) m_armed = 1;
            else if (ev_out && !m_per) m_armed = 0;
            if (reg_wr && reg_addr[5:2] == 4'd2) m_tgt[31:0] = reg_wdata;
            else if (reg_wr && reg_addr[5:2] == 4'd3) m_tgt[63:32] = reg_wdata;
            else if (ev_out && m_per) m_tgt = m_tgt + m_int;
            if (reg_wr && reg_addr[5:2] == 4'd4) m_int[31:0] = reg_wdata;
            if (reg_wr && reg_addr[5:2] == 4'd5) m_int[63:32] = reg_wdata;
            if (reg_wr && reg_addr[5:2] == 4'd0) begin
                m_en = reg_wdata[0]; m_dir = reg_wdata[1]; m_per = reg_wdata[2];
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R4 pin_out vs model", {63'd0, pin_out}, {63'd0, (m_pulse != 0) && m_en && m_dir});
            check("R10 pin_oe vs model", {63'd0, pin_oe}, {63'd0, m_en && m_dir});
            check("R9 reg_rdata vs model", {32'd0, reg_rdata}, {32'd0, m_rdata});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 0;
    endtask

    task automatic rd64(logic [5:0] a, output logic [63:0] d);
        logic [31:0] lo, hw;
        rd(a, lo);
        rd(a + 6'd4, hw);
        d = {hw, lo};
    endtask

    task automatic wr64(logic [5:0] a, logic [63:0] d);
        wr(a, d[31:0]);
        wr(a + 6'd4, d[63:32]);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        logic [63:0] v, t0, tt, tw;
        logic [31:0] w;
        int hi_cnt, nf;
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state
        check("R1 pin_out", {63'd0, pin_out}, 64'd0);
        check("R1 pin_oe", {63'd0, pin_oe}, 64'd0);
        for (int a = 0; a < 40; a += 4) begin
            rd(6'(a), w);
            check("R1 register word", {32'd0, w}, 64'd0);
        end

        // R9: interval register round trip on both words
        wr64(6'h10, 64'h1234_5678_9ABC_DEF0);
        rd64(6'h10, v);
        check("R9 interval readback", v, 64'h1234_5678_9ABC_DEF0);

        // R2: input mode capture
        wr(6'h00, 32'h1);
        @(negedge clk); pin_in = 1; t0 = timer;
        tick(4); pin_in = 0; tick(4);
        rd64(6'h18, v);
        check("R2 input capture time", v, t0 + 64'd3);
        rd(6'h20, w);
        check("R7 snapshot after first input", {32'd0, w}, 64'd1);

        // R3: one-cycle glitch ignored
        @(negedge clk); pin_in = 1;
        tick(1); pin_in = 0; tick(5);
        rd64(6'h18, v);
        check("R3 glitch leaves capture", v, t0 + 64'd3);
        rd(6'h20, w);
        check("R3 glitch leaves count", {32'd0, w}, 64'd1);

        // R3: long hold gives one event
        @(negedge clk); pin_in = 1; tt = timer;
        tick(12); pin_in = 0; tick(4);
        rd(6'h20, w);
        check("R7 snapshot stale until capture read", {32'd0, w}, 64'd1);
        rd64(6'h18, v);
        check("R3 long hold capture", v, tt + 64'd3);
        rd(6'h20, w);
        check("R3 long hold single event", {32'd0, w}, 64'd2);

        // R8: disable clears count
        wr(6'h00, 32'h0);
        rd(6'h18, w);
        rd(6'h20, w);
        check("R8 count cleared", {32'd0, w}, 64'd0);

        // R4 / R10: one-shot output with pin_in wiggling
        tt = timer + 64'd60;
        wr64(6'h08, tt);
        wr(6'h00, 32'h3);
        hi_cnt = 0;
        for (int i = 0; i < 90; i++) begin
            @(negedge clk);
            pin_in = i[1];
            if (pin_out) hi_cnt++;
        end
        pin_in = 0;
        check("R4 pulse width", 64'(hi_cnt), 64'd2);
        rd64(6'h18, v);
        check("R4 output capture", v, tt);
        rd(6'h20, w);
        check("R10 pin ignored in output mode", {32'd0, w}, 64'd1);

        // R6: stays disarmed
        tick(40);
        rd(6'h18, w);
        rd(6'h20, w);
        check("R6 no second one-shot event", {32'd0, w}, 64'd1);

        // R6: target high write re-arms
        tt = timer + 64'd30;
        wr64(6'h08, tt);
        tick(40);
        rd64(6'h18, v);
        check("R6 re-armed capture", v, tt);
        rd(6'h20, w);
        check("R6 re-armed count", {32'd0, w}, 64'd2);

        // R5: periodic
        wr64(6'h10, 64'd9);
        tt = timer + 64'd40;
        wr64(6'h08, tt);
        wr(6'h00, 32'h7);
        while (timer < tt + 64'd31) @(negedge clk);
        @(negedge clk);
        reg_wr = 1; reg_addr = 6'h00; reg_wdata = 32'h5; tw = timer;
        @(negedge clk);
        reg_wr = 0;
        nf = int'((tw - tt) / 64'd9) + 1;
        rd64(6'h08, v);
        check("R5 target advanced", v, tt + 64'd9 * 64'(nf));
        rd64(6'h18, v);
        check("R5 last periodic capture", v, tt + 64'd9 * 64'(nf - 1));
        rd(6'h20, w);
        check("R5 periodic event count", {32'd0, w}, 64'(2 + nf));

        // R10: disabled input mode ignores pin too once disabled
        wr(6'h00, 32'h0);
        @(negedge clk); pin_in = 1; tick(6); pin_in = 0; tick(4);
        rd(6'h18, w);
        rd(6'h20, w);
        check("R10 disabled ignores pin", {32'd0, w}, 64'd0);

        // R8: clear cuts a pulse
        tt = timer + 64'd30;
        wr64(6'h08, tt);
        wr(6'h00, 32'h3);
        while (!pin_out) @(negedge clk);
        reg_wr = 1; reg_addr = 6'h00; reg_wdata = 32'h0;
        @(negedge clk);
        reg_wr = 0;
        check("R8 pulse cut", {63'd0, pin_out}, 64'd0);
        check("R8 oe off", {63'd0, pin_oe}, 64'd0);
        rd(6'h18, w);
        rd(6'h20, w);
        check("R8 count zero after clear", {32'd0, w}, 64'd0);

        tick(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule